// File: doc/BRIEF.md
# Iterative Oldest-First Two-Stage Path Matcher

This block computes, once per time slot, which output-module queue each input-module link of a three-stage switch may serve. It is a scaled-down model of the dispatch matching between the first stage and the bufferless middle stage. There are K input modules, K output modules and M middle-stage paths. For every combination of input module i, output module j and path r, there is a request with a valid bit and the timestamp of its head request.

A `start` pulse loads the request set and clears all match state. Each iteration then takes two clocks:

- **Link phase.** Every unmatched input-module link (i, r) selects its oldest eligible request.
- **Central phase.** Every unmatched middle-stage arbiter (r, j) grants the oldest of the links that forwarded a request to it. It then retires the winner, and the losing requests are barred for the rest of the slot.

After `ITERS` iterations, `done` pulses. The per-link grants, which name the chosen output module, then hold until the next start. A queue may win on several paths in the same slot.

Top module: `clos_ocf_matcher`

## Requirements
- R1: While `rst` is high and after it falls, before any `start`, `grant_valid` is all zero and `done` is low.
- R2: In the link phase, link (i, r) selects, among its eligible requests (i, j, r) over all j, the one with the oldest timestamp. On equal timestamps it selects the largest j.
- R3: In the central phase, arbiter (r, j) grants, among the links (i, r) that selected output j, the one with the oldest timestamp. On equal timestamps it grants the largest i.
- R4: Within one slot, each middle-stage output (r, j) is granted to at most one link, and each link (i, r) holds at most one grant.
- R5: A request is eligible only while it is valid, its link is unmatched, its arbiter (r, j) is unmatched, and it has not lost a central phase earlier in this slot. A request that loses is barred until the next `start`.
- R6: Timestamp a is older than b when bit TS_W-1 of the modulo-2^TS_W difference a-b is 1. Order therefore survives counter wrap while the age gap stays below half the range. For example, 250 is older than 5 with 8-bit stamps.
- R7: `done` is high for exactly one cycle, on the 2*ITERS-th rising edge after the edge that samples `start`. From then until the next `start`, `grant_valid` and `grant_om` stay constant whatever the request inputs do.
- R8: A request whose valid bit was low at `start` is never granted.
- R9: Request (i, j, r) occupies bit (i*K+j)*M+r of `req_valid` and bits of the same slot index times TS_W in `req_ts`. The grant of link (i, r) is bit i*M+r of `grant_valid`. Its output index is field i*M+r, JW bits wide, of `grant_om`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the requests and begins a slot (accepted when idle) |
| req_valid | input | K*K*M | Request valid per (input module, output module, path) |
| req_ts | input | K*K*M*TS_W | Head-request timestamp per request |
| grant_valid | output | K*M | Link (input module, path) holds a grant |
| grant_om | output | K*M*JW | Output module granted to each link |
| done | output | 1 | One-cycle pulse after the last iteration |

## Verification
Two things can happen in the same central phase. One link's request is rejected, and the same arbiter hands its output to another link. The rejected link must then be retried toward a different output in the next link phase.

All-equal timestamps with every request valid force a full rejection cascade across all four iterations. In that case the exact diagonal grant pattern is the verdict. Sweeps with dense requests and narrow timestamp ranges create such collisions in large numbers. Every link's grant is then compared with an arithmetic oldest-first model that steps through the same iterations.

// File: rtl/clos_match_pkg.sv
package clos_match_pkg;
  // a is older than b when the wrapped difference is negative
  function automatic logic ts_older(input logic [15:0] a, input logic [15:0] b,
                                    input int w);
    logic [15:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/oldest_pick.sv
module oldest_pick #(
  parameter int N    = 4,
  parameter int TS_W = 8,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      cand_v,
  input  logic [N*TS_W-1:0] cand_ts,
  output logic              win_v,
  output logic [IW-1:0]     win_idx
);
  import clos_match_pkg::*;

  logic [TS_W-1:0] best_ts;

  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    best_ts = '0;
    for (int c = 0; c < N; c++) begin
      if (cand_v[c] &&
          (!win_v || !ts_older(16'(best_ts), 16'(cand_ts[c*TS_W +: TS_W]), TS_W))) begin
        win_v   = 1'b1;
        win_idx = IW'(c);
        best_ts = cand_ts[c*TS_W +: TS_W];
      end
    end
  end

  // R2/R3: the winner is a requester and no requester is strictly older
  always_comb begin
    if (win_v) begin
      a_win_is_req_r2: assert (cand_v[win_idx]);
      for (int c = 0; c < N; c++) begin
        if (cand_v[c]) begin
          a_no_older_r3: assert (!ts_older(16'(cand_ts[c*TS_W +: TS_W]),
                                           16'(cand_ts[win_idx*TS_W +: TS_W]), TS_W));
        end
      end
    end else begin
      a_none_lost_r2: assert (cand_v == '0);
    end
  end
endmodule

// File: rtl/clos_match_seq.sv
module clos_match_seq #(
  parameter int ITERS = 4,
  localparam int CW   = $clog2(ITERS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ph_load,
  output logic ph_link,
  output logic ph_cent,
  output logic done
);
  typedef enum logic [1:0] {S_IDLE, S_LINK, S_CENT} seq_t;
  seq_t          st;
  logic [CW-1:0] it;

  assign ph_load = (st == S_IDLE) && start;
  assign ph_link = (st == S_LINK);
  assign ph_cent = (st == S_CENT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      it   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin st <= S_LINK; it <= '0; end
        S_LINK: st <= S_CENT;
        default: begin
          if (it == CW'(ITERS - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_LINK;
            it <= it + 1'b1;
          end
        end
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_phase_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_load, ph_link, ph_cent}));
  p_cent_after_link_r7: assert property (@(posedge clk) disable iff (rst)
    ph_link |=> ph_cent);
endmodule

// File: rtl/clos_ocf_matcher.sv
module clos_ocf_matcher #(
  parameter int K     = 4,
  parameter int M     = 4,
  parameter int TS_W  = 8,
  parameter int ITERS = 4,
  localparam int JW   = (K > 1) ? $clog2(K) : 1,
  localparam int NQ   = K * K * M,
  localparam int NL   = K * M
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NQ-1:0]      req_valid,
  input  logic [NQ*TS_W-1:0] req_ts,
  output logic [NL-1:0]      grant_valid,
  output logic [NL*JW-1:0]   grant_om,
  output logic               done
);
  logic ph_load, ph_link, ph_cent;

  clos_match_seq #(.ITERS(ITERS)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .ph_load(ph_load), .ph_link(ph_link), .ph_cent(ph_cent), .done(done)
  );

  logic [NQ-1:0]   vq, inh;
  logic [TS_W-1:0] tq [NQ];
  logic [NL-1:0]   lmat, sel_v, lw_v;
  logic [JW-1:0]   sel_j [NL];
  logic [JW-1:0]   lw_j  [NL];
  logic [JW-1:0]   gom   [NL];
  logic [NL-1:0]   cmat, cw_v;          // indexed r*K+j
  logic [JW-1:0]   cw_i  [NL];

  // link arbiters: one per (input module i, path r)
  for (genvar i = 0; i < K; i++) begin : g_li
    for (genvar r = 0; r < M; r++) begin : g_lr
      logic [K-1:0]      cv;
      logic [K*TS_W-1:0] ct;
      always_comb begin
        for (int j = 0; j < K; j++) begin
          cv[j] = vq[(i*K+j)*M+r] && !inh[(i*K+j)*M+r] &&
                  !cmat[r*K+j] && !lmat[i*M+r];
          ct[j*TS_W +: TS_W] = tq[(i*K+j)*M+r];
        end
      end
      oldest_pick #(.N(K), .TS_W(TS_W)) u_link (
        .cand_v(cv), .cand_ts(ct), .win_v(lw_v[i*M+r]), .win_idx(lw_j[i*M+r]));
    end
  end

  // central arbiters: one per (path r, output module j)
  for (genvar r = 0; r < M; r++) begin : g_cr
    for (genvar j = 0; j < K; j++) begin : g_cj
      logic [K-1:0]      cv;
      logic [K*TS_W-1:0] ct;
      always_comb begin
        for (int i = 0; i < K; i++) begin
          cv[i] = sel_v[i*M+r] && (sel_j[i*M+r] == JW'(j)) && !cmat[r*K+j];
          ct[i*TS_W +: TS_W] = tq[(i*K+j)*M+r];
        end
      end
      oldest_pick #(.N(K), .TS_W(TS_W)) u_cent (
        .cand_v(cv), .cand_ts(ct), .win_v(cw_v[r*K+j]), .win_idx(cw_i[r*K+j]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0; inh <= '0; lmat <= '0; cmat <= '0; sel_v <= '0;
      for (int x = 0; x < NQ; x++) tq[x] <= '0;
      for (int x = 0; x < NL; x++) begin sel_j[x] <= '0; gom[x] <= '0; end
    end else if (ph_load) begin
      vq <= req_valid; inh <= '0; lmat <= '0; cmat <= '0; sel_v <= '0;
      for (int x = 0; x < NQ; x++) tq[x] <= req_ts[x*TS_W +: TS_W];
      for (int x = 0; x < NL; x++) gom[x] <= '0;
    end else if (ph_link) begin
      sel_v <= lw_v;
      for (int x = 0; x < NL; x++) sel_j[x] <= lw_j[x];
    end else if (ph_cent) begin
      sel_v <= '0;
      for (int c = 0; c < NL; c++) begin
        if (cw_v[c]) begin
          lmat[int'(cw_i[c])*M + c/K] <= 1'b1;
          gom[int'(cw_i[c])*M + c/K]  <= JW'(c % K);
          cmat[c]                     <= 1'b1;
        end
      end
      for (int x = 0; x < NL; x++) begin
        if (sel_v[x] && !(cw_v[(x%M)*K + int'(sel_j[x])] &&
                          cw_i[(x%M)*K + int'(sel_j[x])] == JW'(x/M)))
          inh[((x/M)*K + int'(sel_j[x]))*M + x%M] <= 1'b1;
      end
    end
  end

  assign grant_valid = lmat;
  always_comb for (int x = 0; x < NL; x++) grant_om[x*JW +: JW] = gom[x];

  // R4: each (r, j) output is held by at most one link
  for (genvar r = 0; r < M; r++) begin : g_ar
    for (genvar j = 0; j < K; j++) begin : g_aj
      logic [K-1:0] hold;
      always_comb
        for (int i = 0; i < K; i++)
          hold[i] = lmat[i*M+r] && (gom[i*M+r] == JW'(j));
      p_cm_unique_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(hold) <= 1);
      p_cm_tracks_r4: assert property (@(posedge clk) disable iff (rst)
        (hold != '0) |-> cmat[r*K+j]);
    end
  end

  for (genvar x = 0; x < NL; x++) begin : g_al
    p_grant_valid_req_r8: assert property (@(posedge clk) disable iff (rst)
      lmat[x] |-> vq[((x/M)*K + int'(gom[x]))*M + x%M]);
    p_grant_not_barred_r5: assert property (@(posedge clk) disable iff (rst)
      lmat[x] |-> !inh[((x/M)*K + int'(gom[x]))*M + x%M]);
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ph_load && !ph_cent) |=> $stable(grant_valid) && $stable(grant_om));
endmodule

// File: tb/clos_ocf_matcher_test.sv
module clos_ocf_matcher_test;
  localparam int K = 4, M = 4, W = 8, IT = 4, JW = 2;
  localparam int NQ = K*K*M, NL = K*M;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [NQ-1:0]   rv = '0;
  logic [NQ*W-1:0] rt = '0;
  logic [NL-1:0]   gv;
  logic [NL*JW-1:0] gj;
  logic done;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clos_ocf_matcher #(.K(K), .M(M), .TS_W(W), .ITERS(IT)) uut (
    .clk(clk), .rst(rst), .start(start), .req_valid(rv), .req_ts(rt),
    .grant_valid(gv), .grant_om(gj), .done(done));

  function automatic int qx(int i, int j, int r); return (i*K+j)*M+r; endfunction
  function automatic logic [W-1:0] tsv(int q); return rt[q*W +: W]; endfunction
  function automatic bit older(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] d; d = a - b; return d[W-1];
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  int eg [K][M];   // expected grant per link, -1 = none

  task automatic model();
    bit inh [NQ]; bit lm [K][M]; bit cm [M][K]; bit sv [K][M]; int sj [K][M];
    for (int q = 0; q < NQ; q++) inh[q] = 0;
    for (int i = 0; i < K; i++) for (int r = 0; r < M; r++) begin lm[i][r] = 0; eg[i][r] = -1; end
    for (int r = 0; r < M; r++) for (int j = 0; j < K; j++) cm[r][j] = 0;
    for (int it = 0; it < IT; it++) begin
      for (int i = 0; i < K; i++) for (int r = 0; r < M; r++) begin
        int b; b = -1; sv[i][r] = 0;
        if (!lm[i][r])
          for (int j = 0; j < K; j++)
            if (rv[qx(i,j,r)] && !inh[qx(i,j,r)] && !cm[r][j])
              if (b < 0 || !older(tsv(qx(i,b,r)), tsv(qx(i,j,r)))) b = j;
        if (b >= 0) begin sv[i][r] = 1; sj[i][r] = b; end
      end
      for (int r = 0; r < M; r++) for (int j = 0; j < K; j++) begin
        int b; b = -1;
        for (int i = 0; i < K; i++)
          if (sv[i][r] && sj[i][r] == j)
            if (b < 0 || !older(tsv(qx(b,j,r)), tsv(qx(i,j,r)))) b = i;
        if (b >= 0) begin lm[b][r] = 1; eg[b][r] = j; cm[r][j] = 1; end
      end
      for (int i = 0; i < K; i++) for (int r = 0; r < M; r++)
        if (sv[i][r] && !(lm[i][r] && eg[i][r] == sj[i][r])) inh[qx(i,sj[i][r],r)] = 1;
    end
  endtask

  function automatic int act_g(int i, int r);
    return gv[i*M+r] ? int'(gj[(i*M+r)*JW +: JW]) : -1;
  endfunction

  task automatic run_slot(string rq);
    int cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cnt = 1;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    chk(cnt == 2*IT+1, "R7", "done latency", cnt, 2*IT+1);
    model();
    for (int i = 0; i < K; i++) for (int r = 0; r < M; r++)
      chk(act_g(i,r) == eg[i][r], rq, $sformatf("grant link %0d.%0d", i, r),
          act_g(i,r), eg[i][r]);
    for (int r = 0; r < M; r++) for (int j = 0; j < K; j++) begin
      int n; n = 0;
      for (int i = 0; i < K; i++) if (act_g(i,r) == j) n++;
      chk(n <= 1, "R4", "output granted twice", n, 1);
    end
    for (int i = 0; i < K; i++) for (int r = 0; r < M; r++)
      if (gv[i*M+r]) chk(rv[qx(i,act_g(i,r),r)], "R8", "grant on invalid", 0, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gv == '0, "R1", "grants in reset", int'(gv), 0);
    chk(done == 0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(gv == '0, "R1", "grants after reset", int'(gv), 0);

    // R2 R3 R5: all valid, equal stamps -> diagonal cascade over 4 iterations
    rv = '1;
    for (int q = 0; q < NQ; q++) rt[q*W +: W] = 8'd10;
    run_slot("R5");
    for (int i = 0; i < K; i++) for (int r = 0; r < M; r++)
      chk(act_g(i,r) == i, "R3", "tie cascade", act_g(i,r), i);

    // R6: wrap-around, 250 is older than 5
    rv = '0; rt = '0;
    rv[qx(0,0,0)] = 1; rt[qx(0,0,0)*W +: W] = 8'd250;
    rv[qx(0,1,0)] = 1; rt[qx(0,1,0)*W +: W] = 8'd5;
    run_slot("R6");
    chk(act_g(0,0) == 0, "R6", "wrap compare", act_g(0,0), 0);

    // R7: grants hold while inputs change without start
    begin
      logic [NL-1:0] sv_g; logic [NL*JW-1:0] sv_j;
      sv_g = gv; sv_j = gj;
      rv = '1; rt = '0;
      repeat (5) @(negedge clk);
      chk(gv == sv_g, "R7", "grant_valid held", int'(gv), int'(sv_g));
      chk(gj == sv_j, "R7", "grant_om held", int'(gj), int'(sv_j));
    end

    // R2 R3 R5 R6 R8 R9 sweep: varied density, narrow and wide stamp ranges
    for (int v = 0; v < 400; v++) begin
      int base, span, dens;
      base = (v * 37) % 256;
      span = (v % 3 == 0) ? 3 : 110;
      dens = (v % 5) + 1;
      for (int q = 0; q < NQ; q++) begin
        rv[q] = ($urandom % 6) < dens;
        rt[q*W +: W] = W'(base + int'($urandom % span));
      end
      run_slot((v % 2) ? "R2" : "R9");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule